// File: doc/BRIEF.md
# Power-Up Strap Latch Sequencer

This block runs the power-up sequence of a clock device whose configuration straps share pins with clock outputs. While the supply is still rising, the strap pins act as inputs and every clock output stays tri-stated. When a supply-good indication arrives, the block takes one sample of the straps into internal mode registers. It then turns the strap pins and the other clock pins into outputs that are held low. A settle timer runs on the reference clock, and when it expires the block lets all clocks toggle.

Two latched values shape the rest of the device. The operating-mode strap decides whether two PCI clock pins stay clock outputs or become the CPU-stop and PCI-stop inputs. The frequency strap decides whether the shared fixed-frequency pin carries 24 MHz or 48 MHz. The straps are sampled only once after a true power-on reset. If supply-good drops, the sequencer goes back to the tri-state phase, but the stored straps are kept.

Top module: `pwrup_strap_seq`

## Requirements
- R1: During and right after reset, strap_oe, clk_oe and clk_run are 0, straps_latched is 0, seq_state is 0 (tri-state phase), and mode_latched and sel48_latched both read 1.
- R2: A strap whose strap_drive bit is 0 is taken as 1, as if a weak pull-up were present. Bit 0 of the strap vectors is the mode strap and bit 1 is the frequency strap.
- R3: supply_good passes through a two-stage synchronizer. On the first power-up the straps are sampled in a single latch cycle, and clk_oe rises on the fourth rising clock edge after supply_good goes high.
- R4: Once straps_latched is 1, mode_latched and sel48_latched do not change again until the next reset, whatever the strap inputs do and however often supply_good drops.
- R5: In the hold phase, strap_oe and clk_oe are 1 and clk_run is 0. The hold phase lasts exactly SETTLE_CYCLES clock cycles.
- R6: When the settle timer expires, clk_run rises and stays high while supply_good stays high.
- R7: With a latched mode of 0, stop_inputs_en is 1 and pci_dual_oe is 0. With a latched mode of 1, stop_inputs_en is 0 and pci_dual_oe follows clk_oe.
- R8: shared_is_24 equals the latched frequency strap: 1 selects 24 MHz and 0 selects 48 MHz.
- R9: When supply_good goes low, all output enables and clk_run are 0 by the third rising edge afterwards, and seq_state returns to 0.
- R10: After a supply dropout the sequencer skips the latch cycle. clk_oe rises on the third rising edge after supply_good goes high again, and the full settle count is repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that times the sequencer and the settle timer |
| rst_n | input | 1 | True power-on reset, active low |
| supply_good | input | 1 | Supply-above-threshold indication, asynchronous |
| strap_drive | input | NUM_STRAPS | Per strap: 1 when the board drives the pin, 0 when it is left open |
| strap_level | input | NUM_STRAPS | Per strap: the level driven onto the pin |
| straps_latched | output | 1 | The strap sample has been taken |
| mode_latched | output | 1 | Stored operating-mode strap |
| sel48_latched | output | 1 | Stored frequency strap |
| strap_oe | output | 1 | Strap pins act as outputs |
| clk_oe | output | 1 | Clock pins leave tri-state and are driven |
| clk_run | output | 1 | Driven clocks may toggle; when 0 they are held low |
| stop_inputs_en | output | 1 | The two dual pins act as stop inputs |
| pci_dual_oe | output | 1 | The two dual pins are driven as PCI clocks |
| shared_is_24 | output | 1 | Shared pin source: 1 selects 24 MHz, 0 selects 48 MHz |
| seq_state | output | 2 | Phase: 0 tri-state, 1 latch, 2 hold low, 3 run |

## Verification
The assertions check these rules on every cycle:
- the stored straps never move once the sample has been taken;
- clocks never toggle unless their pins are driven;
- the dual pins are never driven while the mode selects stop inputs;
- the pins never leave tri-state before a sample exists;
- every hold phase lasts exactly the settle count before the clocks run.

Some behaviour only the bench scenarios can show. These are the exact latency from supply_good to the first enable, the shorter latency after a dropout, and the pull-up default for open straps. The bench also shows that strap values changed after a dropout are ignored, and that a dropout in the middle of the hold phase restarts the full count.

// File: rtl/pwrup_strap_pkg.sv
package pwrup_strap_pkg;

    typedef enum logic [1:0] {
        SEQ_TRISTATE = 2'd0,
        SEQ_LATCH    = 2'd1,
        SEQ_HOLD_LOW = 2'd2,
        SEQ_RUN      = 2'd3
    } seq_state_e;

    localparam int STRAP_MODE_IDX  = 0;
    localparam int STRAP_SEL48_IDX = 1;
    localparam int NUM_STRAPS_MIN  = 2;

    typedef struct packed {
        seq_state_e st;
    } seq_regs_t;

endpackage

// File: rtl/psl_sync.sv
module psl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sync_d = din;
        end else begin : g_many
            always_comb sync_d = {sync_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/psl_strap_capture.sv
module psl_strap_capture #(
    parameter int NUM_STRAPS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture,
    input  logic [NUM_STRAPS-1:0] strap_drive,
    input  logic [NUM_STRAPS-1:0] strap_level,
    output logic [NUM_STRAPS-1:0] straps_q,
    output logic                  valid_q
);
    logic [NUM_STRAPS-1:0] pin_val;
    logic [NUM_STRAPS-1:0] straps_d;
    logic                  valid_d;

    // An open pin resolves to 1 through the modelled weak pull-up.
    generate
        for (genvar i = 0; i < NUM_STRAPS; i++) begin : g_pin
            assign pin_val[i] = strap_drive[i] ? strap_level[i] : 1'b1;
        end
    endgenerate

    // The sample is taken once per reset; valid_q locks out every later capture.
    always_comb begin
        straps_d = straps_q;
        valid_d  = valid_q;
        if (capture && !valid_q) begin
            straps_d = pin_val;
            valid_d  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            straps_q <= '1;
            valid_q  <= 1'b0;
        end else begin
            straps_q <= straps_d;
            valid_q  <= valid_d;
        end
    end
endmodule

// File: rtl/psl_settle_timer.sv
module psl_settle_timer #(
    parameter int SETTLE_CYCLES = 42955
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    output logic expire
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (count_en && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = count_en && (cnt_q == LAST);
endmodule

// File: rtl/pwrup_strap_seq.sv
module pwrup_strap_seq
    import pwrup_strap_pkg::*;
#(
    parameter int NUM_STRAPS    = 2,
    parameter int SYNC_STAGES   = 2,
    parameter int SETTLE_CYCLES = 42955
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  supply_good,
    input  logic [NUM_STRAPS-1:0] strap_drive,
    input  logic [NUM_STRAPS-1:0] strap_level,
    output logic                  straps_latched,
    output logic                  mode_latched,
    output logic                  sel48_latched,
    output logic                  strap_oe,
    output logic                  clk_oe,
    output logic                  clk_run,
    output logic                  stop_inputs_en,
    output logic                  pci_dual_oe,
    output logic                  shared_is_24,
    output logic [1:0]            seq_state
);
    logic                  sg_sync;
    logic                  capture;
    logic                  settle_done;
    logic [NUM_STRAPS-1:0] straps_q;
    logic                  valid_q;
    seq_regs_t             r_d, r_q;

    psl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (supply_good),
        .dout  (sg_sync)
    );

    psl_strap_capture #(.NUM_STRAPS(NUM_STRAPS)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (capture),
        .strap_drive (strap_drive),
        .strap_level (strap_level),
        .straps_q    (straps_q),
        .valid_q     (valid_q)
    );

    psl_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (r_q.st == SEQ_HOLD_LOW && sg_sync),
        .expire   (settle_done)
    );

    always_comb begin
        r_d     = r_q;
        capture = 1'b0;
        if (!sg_sync) begin
            r_d.st = SEQ_TRISTATE;
        end else begin
            unique case (r_q.st)
                SEQ_TRISTATE: r_d.st = valid_q ? SEQ_HOLD_LOW : SEQ_LATCH;
                SEQ_LATCH: begin
                    capture = 1'b1;
                    r_d.st  = SEQ_HOLD_LOW;
                end
                SEQ_HOLD_LOW: if (settle_done) r_d.st = SEQ_RUN;
                SEQ_RUN:      r_d.st = SEQ_RUN;
                default:      r_d.st = SEQ_TRISTATE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: SEQ_TRISTATE};
        else        r_q <= r_d;
    end

    logic driven;
    assign driven         = (r_q.st == SEQ_HOLD_LOW) || (r_q.st == SEQ_RUN);
    assign straps_latched = valid_q;
    assign mode_latched   = straps_q[STRAP_MODE_IDX];
    assign sel48_latched  = straps_q[STRAP_SEL48_IDX];
    assign strap_oe       = driven;
    assign clk_oe         = driven;
    assign clk_run        = (r_q.st == SEQ_RUN);
    assign stop_inputs_en = valid_q && !straps_q[STRAP_MODE_IDX];
    assign pci_dual_oe    = driven && straps_q[STRAP_MODE_IDX];
    assign shared_is_24   = straps_q[STRAP_SEL48_IDX];
    assign seq_state      = r_q.st;
endmodule

// File: rtl/pwrup_strap_seq_checker.sv
module pwrup_strap_seq_checker #(
    parameter int SETTLE_CYCLES = 42955
) (
    input logic clk,
    input logic rst_n,
    input logic straps_latched,
    input logic mode_latched,
    input logic sel48_latched,
    input logic clk_oe,
    input logic clk_run,
    input logic pci_dual_oe
);
    int unsigned hold_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 hold_cnt_q <= 0;
        else if (!clk_oe)           hold_cnt_q <= 0;
        else if (!clk_run)          hold_cnt_q <= hold_cnt_q + 1;
    end

    assert_straps_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(straps_latched) |-> ($stable(mode_latched) && $stable(sel48_latched)));

    assert_run_needs_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_run |-> clk_oe);

    assert_no_drive_on_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pci_dual_oe |-> mode_latched);

    assert_drive_after_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clk_oe |-> straps_latched);

    assert_settle_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_run) |-> (hold_cnt_q == SETTLE_CYCLES));
endmodule

bind pwrup_strap_seq pwrup_strap_seq_checker #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .straps_latched (straps_latched),
    .mode_latched   (mode_latched),
    .sel48_latched  (sel48_latched),
    .clk_oe         (clk_oe),
    .clk_run        (clk_run),
    .pci_dual_oe    (pci_dual_oe)
);

// File: tb/pwrup_strap_seq_bench.sv
`timescale 1ns/1ps
module pwrup_strap_seq_bench;
    localparam int SETTLE = 37;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_good = 1'b0;
    logic [1:0] strap_drive = 2'b00;
    logic [1:0] strap_level = 2'b00;
    logic straps_latched, mode_latched, sel48_latched, strap_oe, clk_oe, clk_run;
    logic stop_inputs_en, pci_dual_oe, shared_is_24;
    logic [1:0] seq_state;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwrup_strap_seq #(.NUM_STRAPS(2), .SYNC_STAGES(2), .SETTLE_CYCLES(SETTLE)) u_pwrup_strap_seq (
        .clk(clk), .rst_n(rst_n), .supply_good(supply_good),
        .strap_drive(strap_drive), .strap_level(strap_level),
        .straps_latched(straps_latched), .mode_latched(mode_latched),
        .sel48_latched(sel48_latched), .strap_oe(strap_oe), .clk_oe(clk_oe),
        .clk_run(clk_run), .stop_inputs_en(stop_inputs_en),
        .pci_dual_oe(pci_dual_oe), .shared_is_24(shared_is_24), .seq_state(seq_state)
    );

    function automatic bit pin_value(bit drv, bit lvl);
        return drv ? lvl : 1'b1;
    endfunction

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: act %0d cycles exp below 150000", cycles);
            report();
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; supply_good = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!strap_oe && !clk_oe && !clk_run, "R1", "enables", {strap_oe, clk_oe, clk_run}, 0);
        chk(!straps_latched && seq_state == 2'd0, "R1", "valid/state", {straps_latched, seq_state}, 0);
        chk(mode_latched && sel48_latched, "R1", "strap defaults", {mode_latched, sel48_latched}, 3);
    endtask

    // Count every negedge sample of the hold phase, then confirm run.
    task automatic measure_hold(bit em, bit es);
        int n = 0;
        chk(strap_oe == 1'b1, "R5", "strap_oe in hold", strap_oe, 1);
        chk(pci_dual_oe == em && stop_inputs_en == !em, "R7", "dual pins in hold",
            {pci_dual_oe, stop_inputs_en}, {em, !em});
        while (clk_oe && !clk_run && n < SETTLE + 10) begin
            n++;
            @(negedge clk);
        end
        chk(n == SETTLE, "R5", "hold length", n, SETTLE);
        chk(clk_run && clk_oe && seq_state == 2'd3, "R6", "run", {clk_run, seq_state}, 7);
        chk(mode_latched == em && stop_inputs_en == !em && pci_dual_oe == em,
            "R7", "mode decode in run", {mode_latched, stop_inputs_en, pci_dual_oe},
            {em, !em, em});
        chk(sel48_latched == es && shared_is_24 == es, "R8", "shared pin source",
            {sel48_latched, shared_is_24}, {es, es});
    endtask

    task automatic power_up(bit first, bit em, bit es);
        @(negedge clk);
        supply_good = 1'b1;
        repeat (first ? 3 : 2) @(posedge clk);
        @(negedge clk);
        chk(!clk_oe, first ? "R3" : "R10", "early enable", clk_oe, 0);
        @(posedge clk);
        @(negedge clk);
        chk(clk_oe && straps_latched, first ? "R3" : "R10", "enable latency",
            {clk_oe, straps_latched}, 3);
        measure_hold(em, es);
    endtask

    task automatic drop_supply(bit em, bit es);
        @(negedge clk);
        supply_good = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(clk_run == 1'b1, "R9", "still running before sync", clk_run, 1);
        @(posedge clk);
        @(negedge clk);
        chk(!strap_oe && !clk_oe && !clk_run && !pci_dual_oe && seq_state == 2'd0, "R9",
            "back to tri-state", {strap_oe, clk_oe, clk_run, pci_dual_oe}, 0);
        chk(straps_latched && mode_latched == em && sel48_latched == es, "R4",
            "straps kept over dropout", {straps_latched, mode_latched, sel48_latched},
            {1'b1, em, es});
    endtask

    initial begin
        bit em, es;
        void'($urandom(32'd2024));

        // Open straps: pull-up gives mode 1, 24 MHz.
        strap_drive = 2'b00; strap_level = 2'b00;
        do_reset();
        power_up(1'b1, 1'b1, 1'b1);
        chk(mode_latched && sel48_latched, "R2", "open straps read 1", {mode_latched, sel48_latched}, 3);

        // Driven low: stop inputs, 48 MHz; then change straps and re-power.
        strap_drive = 2'b11; strap_level = 2'b00;
        do_reset();
        power_up(1'b1, 1'b0, 1'b0);
        drop_supply(1'b0, 1'b0);
        strap_level = 2'b11;
        power_up(1'b0, 1'b0, 1'b0);
        chk(!mode_latched && !sel48_latched, "R4", "no re-latch", {mode_latched, sel48_latched}, 0);

        // Dropout in the middle of the hold phase restarts the full count.
        strap_drive = 2'b01; strap_level = 2'b00;
        do_reset();
        @(negedge clk);
        supply_good = 1'b1;
        repeat (14) @(negedge clk);
        supply_good = 1'b0;
        repeat (4) @(negedge clk);
        chk(!clk_oe && seq_state == 2'd0, "R9", "mid-hold dropout", clk_oe, 0);
        power_up(1'b0, 1'b0, 1'b1);

        // Random power-ups with random strap wiring.
        for (int k = 0; k < 8; k++) begin
            strap_drive = 2'($urandom);
            strap_level = 2'($urandom);
            em = pin_value(strap_drive[0], strap_level[0]);
            es = pin_value(strap_drive[1], strap_level[1]);
            do_reset();
            power_up(1'b1, em, es);
            for (int j = 0; j < 2; j++) begin
                drop_supply(em, es);
                strap_drive = 2'($urandom);
                strap_level = 2'($urandom);
                power_up(1'b0, em, es);
            end
        end

        done = 1'b1;
        report();
    end
endmodule